// File: doc/BRIEF.md
# Multi-mode reloadable timer counter

This block is a single 32-bit up-counting timer. A prescaler divides the clock by a power of two from 1 to 4096 to make the count tick. A small register port lets software load the count and the terminal value, pick one of seven modes, read back the capture register, and manage an interrupt flag. Two modes run free: one-shot and continuous. Five modes use the timer input pin: edge counting, input capture, output toggle, gated counting and gate-then-capture. The count register can be read at any time, including while the timer runs.

A period ends on the tick that follows the count reaching the terminal value. At that tick the count reloads to one. Reset clears the count to zero, so the first period after reset is one tick longer than the periods that follow. Every end of period sets the interrupt flag. Software clears the flag by writing a one to it, and the interrupt output is the flag gated by an enable bit.

Top module: `tick_timer`

## Requirements
- R1: After reset, the count, terminal, capture, control and flag registers all read zero, and `tmr_pin_o` and `irq_o` are low.
- R2: While running, each count event adds one to the count. On a count event where the count is already at or above the terminal value, the count reloads to 1 instead and the period ends. With terminal T and a start count of 0, the period therefore ends on the (T+1)-th event; each later period takes T events.
- R3: Control bits [7:4] hold a code n, and the tick comes every 2^n clocks. Codes above 12 act as 12, giving a tick every 4096 clocks. A control write restarts the divider. With division by one, the count changes on the first clock edge after the edge that set the run bit.
- R4: One-shot mode (control bits [3:1] = 0) clears the run bit, control bit 0, at the end of its period, and the count stops at 1.
- R5: Continuous mode (mode 1) keeps the run bit set and starts a new period after each end of period.
- R6: Counter mode (mode 2) ignores the prescaler. Its count events are pin edges: rising edges when control bit 8 is 0, falling edges when it is 1.
- R7: Capture mode (mode 3) counts prescaled ticks. A selected pin edge copies the count into the capture register and sets the flag. The pin passes through a two-flop synchronizer, so a pin change presented just after clock edge j is acted on at edge j+3. The value copied is the count held just before edge j+3.
- R8: Compare mode (mode 4) counts prescaled ticks and inverts `tmr_pin_o` at every end of period.
- R9: Gated mode (mode 5) counts prescaled ticks only while the synchronized pin is at its active level: high when bit 8 is 0, low when it is 1. A pin held active for N clocks yields N increments at division by one.
- R10: Gate-then-capture mode (mode 6) counts like gated mode. When the pin leaves its active level, the count is copied to the capture register, the count reloads to 1, and the flag is set.
- R11: The flag (address 4, bit 0) is set by every end of period and by every capture. Writing a 1 to bit 0 clears it, and writing a 0 leaves it unchanged. `irq_o` is high only while both the flag and control bit 9 are set.
- R12: The register addresses are: 0 count (a write overrides counting), 1 terminal, 2 capture (read-only), 3 control, 4 flag. `rd_data_o` shows the register selected by `addr_i` on the clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 3 | Register address for reads and writes |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| tmr_pin_i | input | 1 | Timer input pin, asynchronous |
| tmr_pin_o | output | 1 | Timer output pin, inverted per period in compare mode |
| irq_o | output | 1 | Interrupt request |

## Verification
The in-line properties take some things for granted. The prescale code and the mode change only through a control write, and that write also restarts the divider. The count goes above the terminal value only when software writes it there. Pin edges are assumed to arrive no closer than the synchronizer depth. The directed stimulus therefore changes the mode and prescale fields only while the run bit is clear. It holds every pin level for at least four clocks, and it loads the count before each scenario. The expected periods, captured values and gated increments are then exact cycle counts, derived from the synchronizer and divider latencies stated in the requirements.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  typedef enum logic [2:0] {
    MODE_ONESHOT = 3'd0,
    MODE_CONT    = 3'd1,
    MODE_COUNTER = 3'd2,
    MODE_CAPTURE = 3'd3,
    MODE_COMPARE = 3'd4,
    MODE_GATED   = 3'd5,
    MODE_GATECAP = 3'd6,
    MODE_IDLE    = 3'd7
  } tmr_mode_e;

  // control register layout, most significant field first
  typedef struct packed {
    logic       irq_en;   // bit 9
    logic       pin_pol;  // bit 8
    logic [3:0] psc_code; // bits 7:4
    tmr_mode_e  mode;     // bits 3:1
    logic       run;      // bit 0
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

  localparam logic [2:0] ADDR_COUNT = 3'd0;
  localparam logic [2:0] ADDR_TERM  = 3'd1;
  localparam logic [2:0] ADDR_CAPT  = 3'd2;
  localparam logic [2:0] ADDR_CTRL  = 3'd3;
  localparam logic [2:0] ADDR_FLAG  = 3'd4;

endpackage

// File: rtl/tick_timer_psc.sv
module tick_timer_psc #(
  parameter int CODE_W  = 4,
  parameter int MAX_LOG = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              clr,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);

  localparam int PW = (MAX_LOG < 1) ? 1 : MAX_LOG;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] lim;

  // terminal value of the divider, saturating at 2^MAX_LOG - 1
  always_comb begin
    if (code >= CODE_W'(MAX_LOG)) lim = '1;
    else                          lim = (PW'(1) << code) - PW'(1);
  end

  assign tick = run && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) cnt_q <= '0;
    else if (tick)          cnt_q <= '0;
    else                    cnt_q <= cnt_q + PW'(1);
  end

  // divider never runs beyond the selected limit (code only changes with clr)
  assert_psc_bound_R3: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (cnt_q <= lim));

endmodule

// File: rtl/tick_timer_pinsync.sv
module tick_timer_pinsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic pol,
  output logic level_act,
  output logic edge_act,
  output logic edge_deact
);

  logic [STAGES:0] sh_q;
  logic            cur, prev, rise, fall;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh_q[0] <= 1'b0;
          else     sh_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh_q[g] <= 1'b0;
          else     sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  assign cur  = sh_q[STAGES-1];
  assign prev = sh_q[STAGES];
  assign rise = cur & ~prev;
  assign fall = ~cur & prev;

  assign level_act  = cur ^ pol;
  assign edge_act   = pol ? fall : rise;
  assign edge_deact = pol ? rise : fall;

  // an edge in the synchronized pin follows a level change one stage earlier
  assert_edge_origin_R6: assert property (@(posedge clk) disable iff (rst)
    (rise || fall) |-> (sh_q[STAGES-1] != $past(sh_q[STAGES-1])));

endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  tmr_mode_e        mode,
  input  logic             run,
  input  logic             psc_tick,
  input  logic             level_act,
  input  logic             edge_act,
  input  logic             edge_deact,
  input  logic [CNT_W-1:0] term,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] cap_q,
  output logic             out_q,
  output logic             period_end,
  output logic             cap_evt,
  output logic             halt
);

  logic adv;
  logic gate_reload;

  always_comb begin
    adv = 1'b0;
    if (run) begin
      unique case (mode)
        MODE_ONESHOT, MODE_CONT,
        MODE_CAPTURE, MODE_COMPARE: adv = psc_tick;
        MODE_COUNTER:               adv = edge_act;
        MODE_GATED, MODE_GATECAP:   adv = psc_tick & level_act;
        default:                    adv = 1'b0;
      endcase
    end
  end

  assign period_end  = adv && (count_q >= term);
  assign gate_reload = run && (mode == MODE_GATECAP) && edge_deact;
  assign cap_evt     = (run && (mode == MODE_CAPTURE) && edge_act) || gate_reload;
  assign halt        = period_end && (mode == MODE_ONESHOT);

  always_ff @(posedge clk) begin
    if (rst)                             count_q <= '0;
    else if (cnt_wr)                     count_q <= cnt_wdata;
    else if (period_end || gate_reload)  count_q <= CNT_W'(1);
    else if (adv)                        count_q <= count_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)          cap_q <= '0;
    else if (cap_evt) cap_q <= count_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                                         out_q <= 1'b0;
    else if (period_end && (mode == MODE_COMPARE))   out_q <= ~out_q;
  end

  assert_reload_one_R2: assert property (@(posedge clk) disable iff (rst)
    (period_end && !cnt_wr) |=> (count_q == CNT_W'(1)));

  assert_toggle_R8: assert property (@(posedge clk) disable iff (rst)
    (period_end && mode == MODE_COMPARE) |=> (out_q != $past(out_q)));

  assert_gate_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (run && mode == MODE_GATED && !level_act && !cnt_wr) |=> $stable(count_q));

  assert_cap_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !cap_evt |=> $stable(cap_q));

  assert_gatecap_reload_R10: assert property (@(posedge clk) disable iff (rst)
    (gate_reload && !cnt_wr) |=> (count_q == CNT_W'(1)));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int ADDR_W      = 3,
  parameter int PSC_CODE_W  = 4,
  parameter int PSC_MAX_LOG = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  rd_data_o,
  input  logic              tmr_pin_i,
  output logic              tmr_pin_o,
  output logic              irq_o
);

  localparam int PAD_W = CNT_W - CTRL_W;

  tmr_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] term_q;
  logic             flag_q;
  logic [CNT_W-1:0] count_w, cap_w;
  logic             psc_tick, level_act, edge_act, edge_deact;
  logic             period_end, cap_evt, halt, out_w;
  logic             cnt_wr, ctrl_wr, term_wr, flag_wr;

  assign cnt_wr  = wr_en_i && (addr_i == ADDR_W'(ADDR_COUNT));
  assign term_wr = wr_en_i && (addr_i == ADDR_W'(ADDR_TERM));
  assign ctrl_wr = wr_en_i && (addr_i == ADDR_W'(ADDR_CTRL));
  assign flag_wr = wr_en_i && (addr_i == ADDR_W'(ADDR_FLAG));

  tick_timer_psc #(
    .CODE_W (PSC_CODE_W),
    .MAX_LOG(PSC_MAX_LOG)
  ) u_psc (
    .clk (clk),
    .rst (rst),
    .run (ctrl_q.run),
    .clr (ctrl_wr),
    .code(ctrl_q.psc_code),
    .tick(psc_tick)
  );

  tick_timer_pinsync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst       (rst),
    .pin_i     (tmr_pin_i),
    .pol       (ctrl_q.pin_pol),
    .level_act (level_act),
    .edge_act  (edge_act),
    .edge_deact(edge_deact)
  );

  tick_timer_core #(
    .CNT_W(CNT_W)
  ) u_core (
    .clk       (clk),
    .rst       (rst),
    .mode      (ctrl_q.mode),
    .run       (ctrl_q.run),
    .psc_tick  (psc_tick),
    .level_act (level_act),
    .edge_act  (edge_act),
    .edge_deact(edge_deact),
    .term      (term_q),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (wr_data_i),
    .count_q   (count_w),
    .cap_q     (cap_w),
    .out_q     (out_w),
    .period_end(period_end),
    .cap_evt   (cap_evt),
    .halt      (halt)
  );

  always_ff @(posedge clk) begin
    if (rst)          term_q <= '0;
    else if (term_wr) term_q <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q     <= '0;
    else if (ctrl_wr) ctrl_q     <= tmr_ctrl_t'(wr_data_i[CTRL_W-1:0]);
    else if (halt)    ctrl_q.run <= 1'b0;
  end

  // set wins over a simultaneous write-one-to-clear
  always_ff @(posedge clk) begin
    if (rst)                          flag_q <= 1'b0;
    else if (period_end || cap_evt)   flag_q <= 1'b1;
    else if (flag_wr && wr_data_i[0]) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else begin
      unique case (addr_i)
        ADDR_W'(ADDR_COUNT): rd_data_o <= count_w;
        ADDR_W'(ADDR_TERM):  rd_data_o <= term_q;
        ADDR_W'(ADDR_CAPT):  rd_data_o <= cap_w;
        ADDR_W'(ADDR_CTRL):  rd_data_o <= {{PAD_W{1'b0}}, ctrl_q};
        ADDR_W'(ADDR_FLAG):  rd_data_o <= {{(CNT_W-1){1'b0}}, flag_q};
        default:             rd_data_o <= '0;
      endcase
    end
  end

  assign tmr_pin_o = out_w;
  assign irq_o     = flag_q & ctrl_q.irq_en;

  assert_flag_on_end_R11: assert property (@(posedge clk) disable iff (rst)
    (period_end || cap_evt) |=> flag_q);

  assert_w1c_R11: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && wr_data_i[0] && !period_end && !cap_evt) |=> !flag_q);

  assert_oneshot_halt_R4: assert property (@(posedge clk) disable iff (rst)
    (halt && !ctrl_wr) |=> !ctrl_q.run);

  assert_cont_keeps_run_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.run && ctrl_q.mode == MODE_CONT && !ctrl_wr) |=> ctrl_q.run);

endmodule

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pin = 1'b0;
  logic        pout, irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  tick_timer uut (
    .clk      (clk),
    .rst      (rst),
    .addr_i   (addr),
    .wr_en_i  (wr_en),
    .wr_data_i(wdata),
    .rd_data_o(rdata),
    .tmr_pin_i(pin),
    .tmr_pin_o(pout),
    .irq_o    (irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      pin = 1'b1; step(4);
      pin = 1'b0; step(4);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 reset register", v, 32'h0);
    end
    chk("R1 reset out pin", {31'b0, pout}, 32'h0);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(3'd1, 32'd5);
    wr(3'd3, 32'h201);            // irq enable, one-shot, run
    step(5);
    chk("R2 first period not yet over", {31'b0, irq}, 32'h0);
    step(1);
    chk("R2 first period ends at T+1", {31'b0, irq}, 32'h1);
    step(10);
    rd(3'd3, v);
    chk("R4 one-shot clears run", v, 32'h200);
    rd(3'd0, v);
    chk("R4 count stopped at one", v, 32'h1);
    wr(3'd4, 32'h0);
    rd(3'd4, v);
    chk("R11 write zero keeps flag", v, 32'h1);
    wr(3'd4, 32'h1);
    rd(3'd4, v);
    chk("R11 write one clears flag", v, 32'h0);
    chk("R11 irq drops with flag", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_continuous;
    logic [31:0] v;
    wr(3'd1, 32'd3);
    rd(3'd1, v);
    chk("R12 terminal readback", v, 32'd3);
    wr(3'd3, 32'h003);            // continuous, run, no irq enable
    step(30);
    rd(3'd3, v);
    chk("R5 continuous keeps run", v, 32'h003);
    rd(3'd4, v);
    chk("R11 flag set by period end", v, 32'h1);
    chk("R11 irq masked when disabled", {31'b0, irq}, 32'h0);
    wr(3'd3, 32'h002);
    rd(3'd0, v);
    chk("R5 count within period", {31'b0, (v >= 1 && v <= 3)}, 32'h1);
    wr(3'd4, 32'h1);
  endtask

  task automatic t_compare;
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd4);
    wr(3'd3, 32'h209);            // irq enable, compare, run
    step(4);
    chk("R8 out before first end", {31'b0, pout}, 32'h0);
    step(1);
    chk("R8 out toggles at first end", {31'b0, pout}, 32'h1);
    chk("R11 irq with enable", {31'b0, irq}, 32'h1);
    step(3);
    chk("R2 later period still open", {31'b0, pout}, 32'h1);
    step(1);
    chk("R2 later period is T ticks", {31'b0, pout}, 32'h0);
    wr(3'd3, 32'h008);
    wr(3'd4, 32'h1);
  endtask

  task automatic t_prescale;
    logic [31:0] v;
    wr(3'd0, 32'd0);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd3, 32'h023);            // code 2, continuous, run
    step(40);
    wr(3'd3, 32'h022);
    rd(3'd0, v);
    chk("R3 divide by four", v, 32'd10);
    wr(3'd0, 32'd0);
    wr(3'd3, 32'h0F3);            // code 15 saturates at 4096
    step(4100);
    wr(3'd3, 32'h0F2);
    rd(3'd0, v);
    chk("R3 saturated code", v, 32'd1);
  endtask

  task automatic t_counter;
    logic [31:0] v;
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd3);
    wr(3'd3, 32'h0F5);            // counter, large prescale ignored, run
    pulse(5);
    step(6);
    rd(3'd0, v);
    chk("R6 rising edges wrap at terminal", v, 32'd2);
    rd(3'd4, v);
    chk("R6 counter period sets flag", v, 32'h1);
    wr(3'd3, 32'h0F4);
    wr(3'd4, 32'h1);
    wr(3'd0, 32'd0);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd3, 32'h105);            // falling edges
    pulse(3);
    pin = 1'b1; step(6);
    rd(3'd0, v);
    chk("R6 falling edges only", v, 32'd3);
    wr(3'd3, 32'h104);
    pin = 1'b0; step(6);
  endtask

  task automatic t_capture;
    logic [31:0] v;
    wr(3'd0, 32'd0);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd3, 32'h007);            // capture, run
    step(9);
    pin = 1'b1;
    step(6);
    pin = 1'b0;
    step(6);
    wr(3'd3, 32'h006);
    rd(3'd2, v);
    chk("R7 captured count", v, 32'd11);
    rd(3'd4, v);
    chk("R7 capture sets flag", v, 32'h1);
    wr(3'd4, 32'h1);
  endtask

  task automatic t_gated;
    logic [31:0] v;
    wr(3'd0, 32'd0);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd3, 32'h00B);            // gated, run
    step(8);
    pin = 1'b1; step(20);
    pin = 1'b0; step(10);
    wr(3'd3, 32'h00A);
    rd(3'd0, v);
    chk("R9 counts only while high", v, 32'd20);
  endtask

  task automatic t_gatecap;
    logic [31:0] v;
    wr(3'd0, 32'd0);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd3, 32'h00D);            // gate-then-capture, run
    step(3);
    pin = 1'b1; step(15);
    pin = 1'b0; step(8);
    wr(3'd3, 32'h00C);
    rd(3'd2, v);
    chk("R10 capture on deassert", v, 32'd15);
    rd(3'd0, v);
    chk("R10 count reloads to one", v, 32'd1);
    rd(3'd4, v);
    chk("R10 flag set", v, 32'h1);
    wr(3'd4, 32'h1);
  endtask

  initial begin
    step(4);
    rst = 1'b0;
    t_reset();
    t_oneshot();
    t_continuous();
    t_compare();
    t_prescale();
    t_counter();
    t_capture();
    t_gated();
    t_gatecap();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule